// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a fast system clock into the bit-level timing of a CAN node. A programmable divider cuts the clock into time quanta. A segment controller walks every bit through a one-quantum sync segment, a first timing segment (propagation and phase 1 together) and a second timing segment. At the boundary between the two timing segments it samples the synchronized receive line and raises a sample strobe with the captured level. When the second segment ends it raises a bit-boundary strobe, which the transmit side uses to launch its next bit.

The controller follows the bus in two ways. While the idle input is high, the first recessive-to-dominant transition restarts the bit as a hard synchronization. While a frame is in progress, a falling edge that arrives late or early moves the sample point by at most the programmed jump width. A late edge lengthens the first segment. An early edge shortens the second. Configuration is written through one load strobe. Every length field is stored as its quantum count minus one, and every load restarts the timing cleanly.

Top module: `cbt_bit_timing`

## Requirements
- R1: After reset all strobes are low, `sample_bit` reads 1 (recessive), and the timing runs with the reset configuration: prescaler 6, first segment 11 TQ, second segment 2 TQ and jump width 1 TQ. The first bit boundary therefore comes 84 cycles after reset is released.
- R2: `tq_stb` pulses once every P clock cycles, where P = `cfg_brp_m1` + 1 (1 to 1024).
- R3: With no synchronizing edge, a bit lasts (1 + T1 + T2) * P cycles between `bit_start` pulses. T1 = `cfg_ts1_m1` + 1 (1..16) and T2 = `cfg_ts2_m1` + 1 (1..8).
- R4: `sample_stb` pulses (1 + T1) * P cycles after the `bit_start` of its bit. `sample_bit` holds the level of `rx_raw` after a two-flop synchronizer (0 = dominant, 1 = recessive) and changes only with a sample strobe or a reset/load.
- R5: A falling edge seen in quantum q (counted from 0) of the first segment, after a recessive sample, extends that segment and the bit by min(q + 1, SJ) quanta, where SJ = `cfg_sjw_m1` + 1 (1..4).
- R6: A falling edge seen in quantum q of the second segment, after a recessive sample, shortens that segment and the bit by min(T2 - 1 - q, SJ) quanta.
- R7: A falling edge inside the sync segment leaves the bit length unchanged. A rising edge never causes synchronization.
- R8: At most one synchronization is applied per bit. A second falling edge in the same bit has no effect.
- R9: While `tx_dom` is high, edges in the second segment are ignored and the bit keeps its full length.
- R10: While `bus_idle` is high, a falling edge after a recessive sample causes a hard synchronization. `bit_start` pulses 3 cycles after `rx_raw` falls, the sample strobe follows T1 * P cycles later, and the bit ends (T1 + T2) * P cycles after that `bit_start`.
- R11: A `cfg_load` pulse captures all fields and restarts the divider and the segment state. The first sample strobe comes (1 + T1) * P cycles after the load cycle and the first `bit_start` comes (1 + T1 + T2) * P cycles after it.
- R12: `sample_stb` and `bit_start` never pulse in the same cycle, and a sample strobe always coincides with a `tq_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Captures the configuration fields and restarts timing |
| cfg_brp_m1 | input | 10 | Prescaler minus one (cycles per TQ minus one) |
| cfg_ts1_m1 | input | 4 | First timing segment length minus one |
| cfg_ts2_m1 | input | 3 | Second timing segment length minus one |
| cfg_sjw_m1 | input | 2 | Jump width minus one |
| bus_idle | input | 1 | High between frames; enables hard synchronization |
| tx_dom | input | 1 | High while the node is sending a dominant bit |
| rx_raw | input | 1 | Asynchronous receive line |
| tq_stb | output | 1 | One-cycle pulse at the end of each time quantum |
| bit_start | output | 1 | One-cycle pulse at each bit boundary |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| sample_bit | output | 1 | Bus level captured at the last sample point |

## Verification
Every output is a register. A falling level on `rx_raw` reaches the controller two cycles later and takes effect on the third edge, so a hard-sync `bit_start` is due exactly 3 cycles after the drive. The bench places each injected edge half a quantum into a chosen quantum so that this 3-cycle latency cannot move it across a quantum boundary. Bit and sample positions are measured as whole cycle counts from the `bit_start` (or load/reset) that opens the bit. The bench drives inputs on falling clock edges and reads outputs on falling edges, so each expected count is P times a whole number of quanta, computed from the requirement formulas.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;
endpackage

// File: rtl/cbt_rx_sync.sv
module cbt_rx_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cbt_tq_prescaler.sv
module cbt_tq_prescaler #(
  parameter int BRP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [BRP_W-1:0] brp_m1,
  output logic             tick,
  output logic             tq_stb
);
  logic [BRP_W-1:0] pcnt;

  assign tick = (pcnt == brp_m1);

  always_ff @(posedge clk) begin
    if (rst || restart)  pcnt <= '0;
    else if (tick)       pcnt <= '0;
    else                 pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) tq_stb <= 1'b0;
    else     tq_stb <= tick & ~restart;
  end
endmodule

// File: rtl/cbt_seg_ctrl.sv
module cbt_seg_ctrl
  import cbt_pkg::*;
#(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             tick,
  input  logic             rx_s,
  input  logic             bus_idle,
  input  logic             tx_dom,
  input  logic [TS1_W-1:0] ts1_m1,
  input  logic [TS2_W-1:0] ts2_m1,
  input  logic [SJW_W-1:0] sjw_m1,
  output logic             hard_sync,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_start
);
  localparam int Q_W = $clog2((1 << TS1_W) + (1 << SJW_W) + 1);

  seg_e           seg;
  logic [Q_W-1:0] qcnt, ext_q, shr_q, ext_nx, shr_nx;
  logic [Q_W-1:0] ts1_len, ts2_len, sjw_len, l1, l2, late_err, early_rem;
  logic           sync_done, fall_seen, can_sync, resync;

  assign ts1_len = Q_W'(ts1_m1) + Q_W'(1);
  assign ts2_len = Q_W'(ts2_m1) + Q_W'(1);
  assign sjw_len = Q_W'(sjw_m1) + Q_W'(1);

  // falling edge relative to the level captured at the last sample point
  assign fall_seen = sample_bit & ~rx_s;
  assign can_sync  = fall_seen & ~sync_done;
  assign hard_sync = can_sync & bus_idle;
  assign resync    = can_sync & ~bus_idle & ~((seg == SEG_TS2) & tx_dom);

  assign late_err  = qcnt + Q_W'(1);
  assign early_rem = (qcnt < ts2_len - Q_W'(1)) ? (ts2_len - Q_W'(1) - qcnt) : '0;

  always_comb begin
    ext_nx = ext_q;
    shr_nx = shr_q;
    if (resync && seg == SEG_TS1)
      ext_nx = (late_err < sjw_len) ? late_err : sjw_len;
    if (resync && seg == SEG_TS2)
      shr_nx = (early_rem < sjw_len) ? early_rem : sjw_len;
  end

  assign l1 = ts1_len + ext_nx;
  assign l2 = ts2_len - shr_nx;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      seg        <= SEG_SYNC;
      qcnt       <= '0;
      ext_q      <= '0;
      shr_q      <= '0;
      sync_done  <= 1'b0;
      sample_stb <= 1'b0;
      sample_bit <= 1'b1;
      bit_start  <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      bit_start  <= 1'b0;
      if (hard_sync) begin
        seg       <= SEG_TS1;
        qcnt      <= '0;
        ext_q     <= '0;
        shr_q     <= '0;
        sync_done <= 1'b1;
        bit_start <= 1'b1;
      end else begin
        ext_q <= ext_nx;
        shr_q <= shr_nx;
        if (resync) sync_done <= 1'b1;
        if (tick) begin
          case (seg)
            SEG_SYNC: begin
              seg  <= SEG_TS1;
              qcnt <= '0;
            end
            SEG_TS1: begin
              if (qcnt >= l1 - Q_W'(1)) begin
                seg        <= SEG_TS2;
                qcnt       <= '0;
                sample_stb <= 1'b1;
                sample_bit <= rx_s;
              end else begin
                qcnt <= qcnt + Q_W'(1);
              end
            end
            SEG_TS2: begin
              if (qcnt >= l2 - Q_W'(1)) begin
                seg       <= SEG_SYNC;
                qcnt      <= '0;
                ext_q     <= '0;
                shr_q     <= '0;
                sync_done <= 1'b0;
                bit_start <= 1'b1;
              end else begin
                qcnt <= qcnt + Q_W'(1);
              end
            end
            default: begin
              seg  <= SEG_SYNC;
              qcnt <= '0;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cbt_bit_timing.sv
module cbt_bit_timing #(
  parameter int BRP_W       = 10,
  parameter int TS1_W       = 4,
  parameter int TS2_W       = 3,
  parameter int SJW_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RST_BRP_M1  = 5,
  parameter int RST_TS1_M1  = 10,
  parameter int RST_TS2_M1  = 1,
  parameter int RST_SJW_M1  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [BRP_W-1:0] cfg_brp_m1,
  input  logic [TS1_W-1:0] cfg_ts1_m1,
  input  logic [TS2_W-1:0] cfg_ts2_m1,
  input  logic [SJW_W-1:0] cfg_sjw_m1,
  input  logic             bus_idle,
  input  logic             tx_dom,
  input  logic             rx_raw,
  output logic             tq_stb,
  output logic             bit_start,
  output logic             sample_stb,
  output logic             sample_bit
);
  logic [BRP_W-1:0] brp_r;
  logic [TS1_W-1:0] ts1_r;
  logic [TS2_W-1:0] ts2_r;
  logic [SJW_W-1:0] sjw_r;
  logic             tick, rx_s, hard_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      brp_r <= BRP_W'(RST_BRP_M1);
      ts1_r <= TS1_W'(RST_TS1_M1);
      ts2_r <= TS2_W'(RST_TS2_M1);
      sjw_r <= SJW_W'(RST_SJW_M1);
    end else if (cfg_load) begin
      brp_r <= cfg_brp_m1;
      ts1_r <= cfg_ts1_m1;
      ts2_r <= cfg_ts2_m1;
      sjw_r <= cfg_sjw_m1;
    end
  end

  cbt_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_raw),
    .dout (rx_s)
  );

  cbt_tq_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .restart (cfg_load | hard_sync),
    .brp_m1  (brp_r),
    .tick    (tick),
    .tq_stb  (tq_stb)
  );

  cbt_seg_ctrl #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_seg (
    .clk        (clk),
    .rst        (rst),
    .load       (cfg_load),
    .tick       (tick),
    .rx_s       (rx_s),
    .bus_idle   (bus_idle),
    .tx_dom     (tx_dom),
    .ts1_m1     (ts1_r),
    .ts2_m1     (ts2_r),
    .sjw_m1     (sjw_r),
    .hard_sync  (hard_sync),
    .sample_stb (sample_stb),
    .sample_bit (sample_bit),
    .bit_start  (bit_start)
  );
endmodule

// File: rtl/cbt_bit_timing_chk.sv
module cbt_bit_timing_chk #(
  parameter int BRP_W      = 10,
  parameter int RST_BRP_M1 = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_load,
  input logic [BRP_W-1:0] cfg_brp_m1,
  input logic             hard_sync,
  input logic             tq_stb,
  input logic             bit_start,
  input logic             sample_stb,
  input logic             sample_bit
);
  logic [BRP_W:0]   gap;
  logic [BRP_W-1:0] brp_cur;

  always_ff @(posedge clk) begin
    if (rst) brp_cur <= BRP_W'(RST_BRP_M1);
    else if (cfg_load) brp_cur <= cfg_brp_m1;
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_load || hard_sync) gap <= '0;
    else if (tq_stb)                  gap <= (BRP_W+1)'(1);
    else if (gap != '1)               gap <= gap + 1'b1;
  end

  a_r2_tq_spacing: assert property (@(posedge clk) disable iff (rst)
    tq_stb |-> (gap == {1'b0, brp_cur} + 1'b1));

  a_r12_sample_on_tq: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> tq_stb);

  a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sample_stb, bit_start}));

  a_r4_single_sample: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);

  a_r4_level_held: assert property (@(posedge clk) disable iff (rst)
    (!sample_stb && !$past(cfg_load)) |-> $stable(sample_bit));

  a_r10_hard_boundary: assert property (@(posedge clk) disable iff (rst)
    hard_sync |=> (bit_start && !sample_stb));
endmodule

bind cbt_bit_timing cbt_bit_timing_chk #(.BRP_W(BRP_W), .RST_BRP_M1(RST_BRP_M1)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_load   (cfg_load),
  .cfg_brp_m1 (cfg_brp_m1),
  .hard_sync  (hard_sync),
  .tq_stb     (tq_stb),
  .bit_start  (bit_start),
  .sample_stb (sample_stb),
  .sample_bit (sample_bit)
);

// File: tb/cbt_bit_timing_test.sv
module cbt_bit_timing_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [9:0] cfg_brp_m1 = '0;
  logic [3:0] cfg_ts1_m1 = '0;
  logic [2:0] cfg_ts2_m1 = '0;
  logic [1:0] cfg_sjw_m1 = '0;
  logic       bus_idle = 1'b0;
  logic       tx_dom = 1'b0;
  logic       rx_raw = 1'b1;
  logic       tq_stb, bit_start, sample_stb, sample_bit;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;
  int cp, ct1, ct2, csj;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cbt_bit_timing uut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_brp_m1(cfg_brp_m1),
    .cfg_ts1_m1(cfg_ts1_m1), .cfg_ts2_m1(cfg_ts2_m1), .cfg_sjw_m1(cfg_sjw_m1),
    .bus_idle(bus_idle), .tx_dom(tx_dom), .rx_raw(rx_raw),
    .tq_stb(tq_stb), .bit_start(bit_start), .sample_stb(sample_stb),
    .sample_bit(sample_bit)
  );

  function automatic int fmin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int mid_of_tq(input int tq_index, input int p);
    // drive offset so that the synchronized edge lands half a TQ into tq_index
    return (tq_index * p) + (p / 2) - 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (P=%0d T1=%0d T2=%0d SJ=%0d)",
               req, act, exp, cp, ct1, ct2, csj);
    end
  endtask

  // measure one bit starting at a bit_start negedge; optional rx drives
  task automatic run_bit(input int d_fall, input int d_rise, input int d_fall2,
                         output int s_cnt, output int b_cnt, output int s_val);
    int cnt = 0;
    s_cnt = -1;
    s_val = -1;
    forever begin
      if (cnt == d_fall)  rx_raw = 1'b0;
      if (cnt == d_rise)  rx_raw = 1'b1;
      if (cnt == d_fall2) rx_raw = 1'b0;
      @(negedge clk);
      cnt++;
      if (sample_stb) begin
        s_cnt = cnt;
        s_val = int'(sample_bit);
      end
      if (bit_start || cnt > 20000) break;
    end
    b_cnt = cnt;
  endtask

  task automatic recover();
    int s, b, v;
    rx_raw = 1'b1;
    run_bit(-1, -1, -1, s, b, v);
    run_bit(-1, -1, -1, s, b, v);
  endtask

  // write configuration and check the restart timing (R11); ends aligned
  task automatic load_cfg(input int p, input int t1, input int t2, input int sj);
    int cnt = 0;
    int s_cnt = -1;
    cp = p; ct1 = t1; ct2 = t2; csj = sj;
    cfg_brp_m1 = 10'(p - 1);
    cfg_ts1_m1 = 4'(t1 - 1);
    cfg_ts2_m1 = 3'(t2 - 1);
    cfg_sjw_m1 = 2'(sj - 1);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    forever begin
      @(negedge clk);
      cnt++;
      if (sample_stb) s_cnt = cnt;
      if (bit_start || cnt > 20000) break;
    end
    chk("R11 first sample after load", s_cnt, (1 + t1) * p);
    chk("R11 first boundary after load", cnt, (1 + t1 + t2) * p);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int s, b, v, cnt, gap, q, sh;
    void'($urandom(32'h5eed_c0de));
    cp = 6; ct1 = 11; ct2 = 2; csj = 1;

    // R1: reset state and default timing
    repeat (4) @(negedge clk);
    chk("R1 sample_bit in reset", int'(sample_bit), 1);
    chk("R1 strobes in reset", int'({tq_stb, bit_start, sample_stb}), 0);
    rst = 1'b0;
    cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      if (bit_start || cnt > 5000) break;
    end
    chk("R1 default first boundary", cnt, 84);

    // R2: quantum strobe spacing
    load_cfg(7, 3, 2, 1);
    while (!tq_stb) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tq_stb && gap < 5000);
    chk("R2 tq spacing", gap, 7);

    // R3/R4 on a directed configuration
    load_cfg(4, 5, 6, 4);
    run_bit(-1, -1, -1, s, b, v);
    chk("R3 bit period", b, 48);
    chk("R4 sample offset", s, 24);
    chk("R4 recessive sampled as 1", v, 1);

    // R8: two falling edges in one bit, only the first counts (ext 1)
    run_bit(mid_of_tq(1, 4), mid_of_tq(3, 4), mid_of_tq(4, 4), s, b, v);
    chk("R8 single resync bit length", b, 52);
    chk("R8 single resync sample offset", s, 28);
    chk("R4 dominant sampled as 0", v, 0);

    // R7: rising edge only, no synchronization
    run_bit(-1, mid_of_tq(3, 4), -1, s, b, v);
    chk("R7 rising edge no change", b, 48);
    chk("R7 rising edge sample", v, 1);
    recover();

    // R9: early edge ignored while transmitting dominant
    tx_dom = 1'b1;
    run_bit(mid_of_tq(7, 4), -1, -1, s, b, v);
    chk("R9 tx dominant ignores early edge", b, 48);
    tx_dom = 1'b0;
    run_bit(-1, -1, -1, s, b, v);
    chk("R7 edge in sync segment no change", b, 48);
    recover();

    // R6 directed: early edge at q=1 of TS2 shortens by min(4,4)
    run_bit(mid_of_tq(7, 4), -1, -1, s, b, v);
    chk("R6 early edge shorten", b, 32);
    recover();

    // R10: hard synchronization while idle
    bus_idle = 1'b1;
    cnt = 0;
    repeat (8) @(negedge clk);
    rx_raw = 1'b0;
    forever begin
      @(negedge clk);
      cnt++;
      if (bit_start || cnt > 5000) break;
    end
    chk("R10 hard sync latency", cnt, 3);
    run_bit(-1, -1, -1, s, b, v);
    chk("R10 hard sync sample", s, 20);
    chk("R10 hard sync bit end", b, 44);
    chk("R10 hard sync sampled dominant", v, 0);
    bus_idle = 1'b0;
    recover();

    // random configurations: R3, R4, R5, R6, R7, R11
    for (int it = 0; it < 30; it++) begin
      int p, t1, t2, sj;
      p  = 2 + int'($urandom_range(6));
      t1 = 1 + int'($urandom_range(15));
      t2 = 1 + int'($urandom_range(7));
      sj = 1 + int'($urandom_range(3));
      load_cfg(p, t1, t2, sj);
      run_bit(-1, -1, -1, s, b, v);
      chk("R3 bit period", b, (1 + t1 + t2) * p);
      chk("R4 sample offset", s, (1 + t1) * p);

      q = int'($urandom_range(t1 - 1));
      run_bit(mid_of_tq(1 + q, p), -1, -1, s, b, v);
      chk("R5 late edge bit length", b, (1 + t1 + t2 + fmin(q + 1, sj)) * p);
      chk("R5 late edge sample offset", s, (1 + t1 + fmin(q + 1, sj)) * p);
      recover();

      q = int'($urandom_range(t2 - 1));
      sh = fmin(t2 - 1 - q, sj);
      run_bit(mid_of_tq(1 + t1 + q, p), -1, -1, s, b, v);
      chk("R6 early edge bit length", b, (1 + t1 + t2 - sh) * p);
      chk("R6 early edge sample", v, 1);
      run_bit(-1, -1, -1, s, b, v);
      chk("R7 sync segment edge bit length", b, (1 + t1 + t2) * p);
      recover();
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule